// File: doc/BRIEF.md
# Ping-Pong Receive Buffer for a USB OUT Endpoint

This block sits between the USB serial engine and the CPU on an OUT endpoint. It has two packet buffers. The USB side fills them in turn, one byte per write strobe, and closes each packet with an end strobe. The CPU sees one buffer at a time. It reads the byte count of that buffer from a size output and pops bytes through a read strobe. When it has finished with the packet, it pulses a read-finish trigger. The trigger returns the buffer to the USB side and moves the CPU view to the other buffer.

Packets reach the CPU in the order they arrived. When both buffers hold packets the CPU has not yet released, the block asserts NAK toward the USB side, and any traffic arriving in that state is dropped. A CPU read past the valid byte count is flagged as an overread. A clear input removes stale packets after a cable reconnect. The clear leaves alone any buffer that is still taking in a packet.

Top module: `usb_rx_pingpong`

## Requirements
- R1: Each buffer stores at most MAX_PKT bytes. Bytes that arrive after a packet has reached MAX_PKT are discarded, and its count stays at MAX_PKT.
- R2: While `cpu_data_avail` is 1, `cpu_rx_size` shows the byte count of the exposed buffer. Otherwise it shows 0. Both outputs change in the cycle after the clock edge that commits or releases a packet.
- R3: A `cpu_rd_en` pulse while unread bytes remain puts the next byte, in arrival order, on `cpu_rd_data` after the next clock edge. A pulse with no byte left, or with no packet exposed, sets `cpu_overread` to 1 for one cycle, sets `cpu_rd_data` to 0 and does not advance the read position.
- R4: A `cpu_rd_finish` pulse while `cpu_data_avail` is 1 releases the exposed buffer and moves the view to the other buffer, with its read position reset to the first byte. The size output then shows that buffer's count.
- R5: Packets are stored in the two buffers alternately and delivered in arrival order. A `usb_pkt_end` pulse with no preceding byte is a valid packet of size 0. A byte sent in the same cycle as `usb_pkt_end` belongs to that packet.
- R6: `usb_nak` is 1 whenever both buffers hold unreleased packets. Bytes and end strobes that arrive while it is 1 are dropped. After a release the freed buffer accepts the next packet.
- R7: `fifo_clr` empties every buffer that is not receiving a packet. A buffer that is partway through a packet keeps its bytes and completes normally, and the CPU view moves to it.
- R8: `cpu_data_avail` is 1 exactly when the exposed buffer holds a completed packet that has not been released.
- R9: A `cpu_rd_finish` pulse while `cpu_data_avail` is 0 has no effect.
- R10: After reset, `cpu_data_avail`, `cpu_rx_size`, `usb_nak`, `cpu_overread` and `cpu_rd_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| usb_wr_en | input | 1 | Write strobe for one received byte |
| usb_wr_data | input | DATA_W | Received byte |
| usb_pkt_end | input | 1 | Closes the packet being received |
| usb_nak | output | 1 | Both buffers hold unreleased packets |
| fifo_clr | input | 1 | Clears stale buffers |
| cpu_rd_en | input | 1 | Pops one byte from the exposed buffer |
| cpu_rd_data | output | DATA_W | Byte returned by the previous pop |
| cpu_overread | output | 1 | One-cycle flag: the previous pop went past the byte count |
| cpu_rx_size | output | $clog2(MAX_PKT+1) | Byte count of the exposed buffer |
| cpu_rd_finish | input | 1 | Releases the exposed buffer and swaps the view |
| cpu_data_avail | output | 1 | The exposed buffer holds an unreleased packet |

## Verification
The status outputs `usb_nak`, `cpu_data_avail` and `cpu_rx_size` are decoded directly from the buffer state registers. They are therefore correct one clock edge after the strobe that commits, releases or clears a buffer. The read outputs `cpu_rd_data` and `cpu_overread` are registered on the edge that samples `cpu_rd_en`, so they are also due one edge later. The bench drives every strobe on a falling edge, lets a single rising edge go by, and samples on the next falling edge. Each pop is checked before the next one is issued.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;

    typedef enum logic [1:0] {
        BUF_EMPTY   = 2'd0,
        BUF_FILLING = 2'd1,
        BUF_FULL    = 2'd2
    } buf_state_e;

    typedef struct packed {
        logic wr;
        logic commit;
        logic rel;
        logic clear;
    } bank_cmd_t;

    localparam int unsigned NBUF = 2;

    function automatic logic is_held(input buf_state_e s);
        return s == BUF_FULL;
    endfunction

    function automatic logic is_busy(input buf_state_e s);
        return s == BUF_FILLING;
    endfunction

endpackage

// File: rtl/usbrx_bank.sv
module usbrx_bank
    import usbrx_pkg::*;
#(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned MAX_PKT = 64,
    parameter int unsigned CNT_W   = $clog2(MAX_PKT + 1),
    parameter int unsigned AW      = $clog2(MAX_PKT)
) (
    input  logic              clk,
    input  logic              rst,
    input  bank_cmd_t         cmd,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output buf_state_e        state,
    output logic [CNT_W-1:0]  count,
    output logic [DATA_W-1:0] rd_byte
);

    localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_PKT);

    logic [DATA_W-1:0] mem [MAX_PKT];
    logic              room;
    logic              take;

    assign room    = count < CAP;
    assign take    = cmd.wr && room && !is_held(state);
    assign rd_byte = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (take) begin
            mem[count[AW-1:0]] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= BUF_EMPTY;
            count <= '0;
        end else begin
            unique case (state)
                BUF_EMPTY: begin
                    if (cmd.wr) begin
                        count <= CNT_W'(1);
                        state <= cmd.commit ? BUF_FULL : BUF_FILLING;
                    end else if (cmd.commit) begin
                        count <= '0;
                        state <= BUF_FULL;
                    end
                end
                BUF_FILLING: begin
                    if (take) begin
                        count <= count + CNT_W'(1);
                    end
                    if (cmd.commit) begin
                        state <= BUF_FULL;
                    end
                end
                BUF_FULL: begin
                    if (cmd.clear || cmd.rel) begin
                        state <= BUF_EMPTY;
                        count <= '0;
                    end
                end
                default: begin
                    state <= BUF_EMPTY;
                    count <= '0;
                end
            endcase
        end
    end

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (rst)
        count <= CAP);

    assert_clear_spares_filling_R7: assert property (@(posedge clk) disable iff (rst)
        (state == BUF_FILLING && cmd.clear) |=> state != BUF_EMPTY);

    assert_full_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (state == BUF_FULL && !cmd.rel && !cmd.clear) |=> (state == BUF_FULL && $stable(count)));

endmodule

// File: rtl/usbrx_usb_side.sv
module usbrx_usb_side
    import usbrx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  buf_state_e [NBUF-1:0] st,
    input  logic                  usb_wr_en,
    input  logic                  usb_pkt_end,
    output logic [NBUF-1:0]       wr_vec,
    output logic [NBUF-1:0]       commit_vec,
    output logic                  usb_sel,
    output logic                  usb_nak
);

    logic accept;

    assign usb_nak = is_held(st[usb_sel]);
    assign accept  = !usb_nak;

    always_comb begin
        wr_vec     = '0;
        commit_vec = '0;
        wr_vec[usb_sel]     = usb_wr_en && accept;
        commit_vec[usb_sel] = usb_pkt_end && accept;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            usb_sel <= 1'b0;
        end else if (usb_pkt_end && accept) begin
            usb_sel <= ~usb_sel;
        end
    end

    assert_nak_blocks_commit_R6: assert property (@(posedge clk) disable iff (rst)
        (usb_nak && usb_pkt_end) |=> $stable(usb_sel));

endmodule

// File: rtl/usbrx_cpu_side.sv
module usbrx_cpu_side
    import usbrx_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = 7,
    parameter int unsigned AW     = 6
) (
    input  logic                              clk,
    input  logic                              rst,
    input  buf_state_e [NBUF-1:0]             st,
    input  logic [NBUF-1:0][CNT_W-1:0]        cnt,
    input  logic [NBUF-1:0][DATA_W-1:0]       bytes,
    input  logic                              usb_sel,
    input  logic                              fifo_clr,
    input  logic                              cpu_rd_en,
    input  logic                              cpu_rd_finish,
    output logic [NBUF-1:0]                   rel_vec,
    output logic [AW-1:0]                     rd_addr,
    output logic [DATA_W-1:0]                 cpu_rd_data,
    output logic                              cpu_overread,
    output logic [CNT_W-1:0]                  cpu_rx_size,
    output logic                              cpu_data_avail
);

    logic             cpu_sel;
    logic [CNT_W-1:0] rd_ptr;
    logic             rd_ok;
    logic             finish_ok;

    assign cpu_data_avail = is_held(st[cpu_sel]);
    assign cpu_rx_size    = cpu_data_avail ? cnt[cpu_sel] : '0;
    assign rd_ok          = cpu_rd_en && (rd_ptr < cpu_rx_size);
    assign finish_ok      = cpu_rd_finish && cpu_data_avail;
    assign rd_addr        = rd_ptr[AW-1:0];

    always_comb begin
        rel_vec = '0;
        rel_vec[cpu_sel] = finish_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_sel      <= 1'b0;
            rd_ptr       <= '0;
            cpu_rd_data  <= '0;
            cpu_overread <= 1'b0;
        end else begin
            cpu_overread <= cpu_rd_en && !rd_ok;
            if (cpu_rd_en) begin
                cpu_rd_data <= rd_ok ? bytes[cpu_sel] : '0;
            end
            if (fifo_clr) begin
                cpu_sel <= usb_sel;
                rd_ptr  <= '0;
            end else if (finish_ok) begin
                cpu_sel <= ~cpu_sel;
                rd_ptr  <= '0;
            end else if (rd_ok) begin
                rd_ptr <= rd_ptr + CNT_W'(1);
            end
        end
    end

    assert_ptr_within_size_R3: assert property (@(posedge clk) disable iff (rst)
        rd_ptr <= cpu_rx_size);

    assert_overread_needs_read_R3: assert property (@(posedge clk) disable iff (rst)
        cpu_overread |-> $past(cpu_rd_en));

endmodule

// File: rtl/usb_rx_pingpong.sv
module usb_rx_pingpong
    import usbrx_pkg::*;
#(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned MAX_PKT = 64,
    localparam int unsigned CNT_W  = $clog2(MAX_PKT + 1),
    localparam int unsigned AW     = $clog2(MAX_PKT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              usb_wr_en,
    input  logic [DATA_W-1:0] usb_wr_data,
    input  logic              usb_pkt_end,
    output logic              usb_nak,
    input  logic              fifo_clr,
    input  logic              cpu_rd_en,
    output logic [DATA_W-1:0] cpu_rd_data,
    output logic              cpu_overread,
    output logic [CNT_W-1:0]  cpu_rx_size,
    input  logic              cpu_rd_finish,
    output logic              cpu_data_avail
);

    buf_state_e [NBUF-1:0]        st;
    logic [NBUF-1:0][CNT_W-1:0]   cnt;
    logic [NBUF-1:0][DATA_W-1:0]  bytes;
    logic [NBUF-1:0]              wr_vec;
    logic [NBUF-1:0]              commit_vec;
    logic [NBUF-1:0]              rel_vec;
    logic [AW-1:0]                rd_addr;
    logic                         usb_sel;

    usbrx_usb_side u_usb (
        .clk        (clk),
        .rst        (rst),
        .st         (st),
        .usb_wr_en  (usb_wr_en),
        .usb_pkt_end(usb_pkt_end),
        .wr_vec     (wr_vec),
        .commit_vec (commit_vec),
        .usb_sel    (usb_sel),
        .usb_nak    (usb_nak)
    );

    for (genvar g = 0; g < NBUF; g++) begin : g_bank
        bank_cmd_t cmd;
        assign cmd.wr     = wr_vec[g];
        assign cmd.commit = commit_vec[g];
        assign cmd.rel    = rel_vec[g];
        assign cmd.clear  = fifo_clr;

        usbrx_bank #(
            .DATA_W (DATA_W),
            .MAX_PKT(MAX_PKT),
            .CNT_W  (CNT_W),
            .AW     (AW)
        ) u_bank (
            .clk    (clk),
            .rst    (rst),
            .cmd    (cmd),
            .wr_data(usb_wr_data),
            .rd_addr(rd_addr),
            .state  (st[g]),
            .count  (cnt[g]),
            .rd_byte(bytes[g])
        );
    end

    usbrx_cpu_side #(
        .DATA_W(DATA_W),
        .CNT_W (CNT_W),
        .AW    (AW)
    ) u_cpu (
        .clk           (clk),
        .rst           (rst),
        .st            (st),
        .cnt           (cnt),
        .bytes         (bytes),
        .usb_sel       (usb_sel),
        .fifo_clr      (fifo_clr),
        .cpu_rd_en     (cpu_rd_en),
        .cpu_rd_finish (cpu_rd_finish),
        .rel_vec       (rel_vec),
        .rd_addr       (rd_addr),
        .cpu_rd_data   (cpu_rd_data),
        .cpu_overread  (cpu_overread),
        .cpu_rx_size   (cpu_rx_size),
        .cpu_data_avail(cpu_data_avail)
    );

    assert_nak_implies_avail_R8: assert property (@(posedge clk) disable iff (rst)
        usb_nak |-> cpu_data_avail);

    assert_swap_exposes_next_R4: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd_finish && usb_nak && !fifo_clr) |=> (cpu_data_avail && !usb_nak));

endmodule

// File: tb/usb_rx_pingpong_tb.sv
module usb_rx_pingpong_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DW   = 8;
    localparam int MAXP = 64;
    localparam int CW   = $clog2(MAXP + 1);

    logic          clk = 1'b0;
    logic          rst;
    logic          usb_wr_en, usb_pkt_end, fifo_clr;
    logic [DW-1:0] usb_wr_data;
    logic          usb_nak;
    logic          cpu_rd_en, cpu_rd_finish;
    logic [DW-1:0] cpu_rd_data;
    logic          cpu_overread, cpu_data_avail;
    logic [CW-1:0] cpu_rx_size;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    usb_rx_pingpong #(.DATA_W(DW), .MAX_PKT(MAXP)) u_dut (
        .clk(clk), .rst(rst),
        .usb_wr_en(usb_wr_en), .usb_wr_data(usb_wr_data), .usb_pkt_end(usb_pkt_end),
        .usb_nak(usb_nak), .fifo_clr(fifo_clr),
        .cpu_rd_en(cpu_rd_en), .cpu_rd_data(cpu_rd_data), .cpu_overread(cpu_overread),
        .cpu_rx_size(cpu_rx_size), .cpu_rd_finish(cpu_rd_finish), .cpu_data_avail(cpu_data_avail)
    );

    task automatic check(input string req, input int actual, input int expected);
        tests++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic send_pkt(input int n, input int base, input bit close);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            usb_wr_en   = 1'b1;
            usb_wr_data = DW'(base + i);
            usb_pkt_end = close && (i == n - 1);
        end
        if (n == 0 && close) begin
            @(negedge clk);
            usb_pkt_end = 1'b1;
        end
        @(negedge clk);
        usb_wr_en   = 1'b0;
        usb_pkt_end = 1'b0;
    endtask

    task automatic pop(output int data, output int ovr);
        @(negedge clk);
        cpu_rd_en = 1'b1;
        @(negedge clk);
        cpu_rd_en = 1'b0;
        data = int'(cpu_rd_data);
        ovr  = int'(cpu_overread);
    endtask

    task automatic finish_pkt();
        @(negedge clk);
        cpu_rd_finish = 1'b1;
        @(negedge clk);
        cpu_rd_finish = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        fifo_clr = 1'b1;
        @(negedge clk);
        fifo_clr = 1'b0;
    endtask

    task automatic test_reset();
        check("R10 avail", int'(cpu_data_avail), 0);
        check("R10 size", int'(cpu_rx_size), 0);
        check("R10 nak", int'(usb_nak), 0);
        check("R10 overread", int'(cpu_overread), 0);
        check("R10 rd_data", int'(cpu_rd_data), 0);
    endtask

    task automatic test_basic();
        int d, o;
        send_pkt(5, 'h10, 1'b1);
        check("R8 avail after packet", int'(cpu_data_avail), 1);
        check("R2 size", int'(cpu_rx_size), 5);
        check("R6 nak with one packet", int'(usb_nak), 0);
        for (int i = 0; i < 5; i++) begin
            pop(d, o);
            check("R3 byte", d, 'h10 + i);
            check("R3 no overread", o, 0);
        end
        pop(d, o);
        check("R3 overread flag", o, 1);
        check("R3 overread data", d, 0);
        @(negedge clk);
        check("R3 overread one cycle", int'(cpu_overread), 0);
        finish_pkt();
        check("R4 avail after release", int'(cpu_data_avail), 0);
        check("R2 size after release", int'(cpu_rx_size), 0);
    endtask

    task automatic test_pingpong();
        int d, o;
        send_pkt(3, 'h20, 1'b1);
        send_pkt(4, 'h40, 1'b1);
        check("R6 nak both held", int'(usb_nak), 1);
        check("R5 first packet first", int'(cpu_rx_size), 3);
        send_pkt(2, 'h60, 1'b1);
        check("R6 nak still", int'(usb_nak), 1);
        pop(d, o);
        check("R5 first packet byte", d, 'h20);
        finish_pkt();
        check("R4 size of next buffer", int'(cpu_rx_size), 4);
        check("R6 nak released", int'(usb_nak), 0);
        pop(d, o);
        check("R4 read restarts at first byte", d, 'h40);
        finish_pkt();
        check("R6 dropped packet absent", int'(cpu_data_avail), 0);
        send_pkt(2, 'h70, 1'b1);
        check("R6 freed buffer accepts", int'(cpu_rx_size), 2);
        pop(d, o);
        check("R6 freed buffer data", d, 'h70);
        finish_pkt();
    endtask

    task automatic test_overflow();
        int d, o;
        send_pkt(MAXP + 3, 0, 1'b1);
        check("R1 size saturates", int'(cpu_rx_size), MAXP);
        for (int i = 0; i < MAXP; i++) begin
            pop(d, o);
            check("R1 stored byte", d, i & 'hff);
        end
        pop(d, o);
        check("R1 extra bytes discarded", o, 1);
        finish_pkt();
    endtask

    task automatic test_zero_len();
        int d, o;
        send_pkt(0, 0, 1'b1);
        check("R5 zero-length avail", int'(cpu_data_avail), 1);
        check("R5 zero-length size", int'(cpu_rx_size), 0);
        pop(d, o);
        check("R3 overread on empty packet", o, 1);
        finish_pkt();
        check("R4 zero-length released", int'(cpu_data_avail), 0);
    endtask

    task automatic test_finish_ignored();
        int d, o;
        finish_pkt();
        check("R9 avail stays low", int'(cpu_data_avail), 0);
        send_pkt(2, 'h30, 1'b1);
        check("R9 view unchanged avail", int'(cpu_data_avail), 1);
        check("R9 view unchanged size", int'(cpu_rx_size), 2);
        pop(d, o);
        check("R9 view unchanged data", d, 'h30);
        finish_pkt();
    endtask

    task automatic test_clear();
        int d, o;
        send_pkt(3, 'hA0, 1'b1);
        send_pkt(2, 'hB0, 1'b0);
        pulse_clear();
        check("R7 stale packet removed", int'(cpu_data_avail), 0);
        send_pkt(1, 'hB2, 1'b1);
        check("R7 receiving packet kept", int'(cpu_data_avail), 1);
        check("R7 receiving packet size", int'(cpu_rx_size), 3);
        for (int i = 0; i < 3; i++) begin
            pop(d, o);
            check("R7 receiving packet data", d, 'hB0 + i);
        end
        finish_pkt();
        send_pkt(1, 'hC0, 1'b1);
        send_pkt(1, 'hC1, 1'b1);
        check("R6 nak before clear", int'(usb_nak), 1);
        pulse_clear();
        check("R7 clear both held nak", int'(usb_nak), 0);
        check("R7 clear both held avail", int'(cpu_data_avail), 0);
        check("R7 clear both held size", int'(cpu_rx_size), 0);
        send_pkt(2, 'hD0, 1'b1);
        pop(d, o);
        check("R7 usable after clear", d, 'hD0);
        finish_pkt();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        usb_wr_en = 1'b0; usb_pkt_end = 1'b0; usb_wr_data = '0;
        fifo_clr = 1'b0; cpu_rd_en = 1'b0; cpu_rd_finish = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_basic();
        test_pingpong();
        test_overflow();
        test_zero_len();
        test_finish_ignored();
        test_clear();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule